// File: doc/BRIEF.md
# Firmware Window Decoder with Bridge Configuration Registers

This block sits inside an ISA/LPC bridge. It holds a small group of configuration registers that are reached through 32-bit configuration-space accesses with per-byte enables. It also holds a purely combinational memory-address decoder. The decoder tells the bridge whether a memory address falls into one of the firmware-device windows, and which of the eight firmware devices owns that address.

One register byte, the decode mask, gives each firmware device two 512 KB windows that mirror each other. The primary window lies in the top 4 MB of the 32-bit space. The mirror lies 4 MB below it. The highest device also owns the legacy 128 KB shadow region just under 1 MB, and its mask bit is locked to one.

A second 16-bit register carries an enable bit for the super I/O index/data port pair, and that bit is brought out as a pin. The remaining registers are plain storage: three legacy range bytes, a generic decode word and a firmware select word. Their values are kept for the rest of the bridge.

Top module: `lpc_fw_decode_top`

## Requirements
- R1: After reset, a read of dword 0xE0 returns 0xFF000000, dword 0xE4 returns 0x20000000 and dword 0xE8 returns 0x00112233. This means the mask byte is 0xFF, the port-enable word is 0x2000, the generic word is 0 and the range bytes are 0.
- R2: A write changes only the bytes whose byte enable is 1; byte i of the dword is cfg_wdata[8i+7:8i]. Nothing is written while cfg_wr_en is 0.
- R3: Within dword 0xE0, byte 0 holds the com range, byte 1 the floppy/parallel range, byte 2 the sound range and byte 3 the decode mask. Any write to byte 3 stores the written value with bit 7 forced to 1.
- R4: If mem_addr lies in 0xFFC00000 + n*0x80000 (512 KB) and mask bit n is 1, then fw_hit is 1 and fw_dev_sel is n.
- R5: If mem_addr lies in the mirror window 0xFF800000 + n*0x80000 and mask bit n is 1, then fw_hit is 1 and fw_dev_sel is n.
- R6: If mem_addr is in 0x000E0000..0x000FFFFF and mask bit 7 is 1, then fw_hit is 1 and fw_dev_sel is 7.
- R7: An address in no enabled window drives fw_hit to 0 and fw_dev_sel to 0. This covers a window whose mask bit is 0, addresses below 0xFF800000 and addresses next to the legacy region.
- R8: Dword 0xE4 holds the generic decode word in bits 15:0 and the port-enable word in bits 31:16. sio_port_en equals bit 13 of the port-enable word, that is bit 29 of dword 0xE4.
- R9: Dword 0xFC reads as zero, and writes to it change no register.
- R10: Reads of any dword other than 0xE0, 0xE4 and 0xE8 return zero.
- R11: cfg_rdata, fw_hit and fw_dev_sel follow their inputs in the same cycle. A write becomes visible after the rising clock edge that samples cfg_wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe for one cycle |
| cfg_addr | input | 8 | Configuration byte offset; bits 1:0 are ignored |
| cfg_byte_en | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| mem_addr | input | 32 | Memory address to decode |
| fw_hit | output | 1 | Address falls in an enabled firmware window |
| fw_dev_sel | output | 3 | Firmware device index for the hit |
| sio_port_en | output | 1 | Enable for the super I/O index/data ports |

## Verification
Three kinds of result are checked, each at the cycle it is due. Read data and the decoder outputs have no register in their path, so the bench changes the input at a falling edge and samples one nanosecond later, in the same cycle. A write is sampled by the next rising edge. The bench therefore raises the strobe at a falling edge, drops it at the following falling edge, and reads back only after that, when the register already holds the new value. The sio_port_en pin is sampled in the same way, after the edge that takes the write.

// File: rtl/lpc_fw_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the firmware window decoder.
// Assumes 32-bit configuration dwords addressed by byte offset.
package lpc_fw_pkg;
    localparam int CFG_DW        = 32;
    localparam int CFG_BYTES     = CFG_DW / 8;
    localparam int FW_DEVS       = 8;
    localparam int FW_SEL_W      = $clog2(FW_DEVS);
    localparam int FW_LOCK_BIT   = FW_DEVS - 1;
    localparam int PORT_EN_BIT   = 13;

    // Dword indices (byte offset >> 2)
    localparam logic [5:0] DW_RANGES = 6'h38;  // 0xE0
    localparam logic [5:0] DW_DECODE = 6'h39;  // 0xE4
    localparam logic [5:0] DW_SELECT = 6'h3A;  // 0xE8
    localparam logic [5:0] DW_UNDOC  = 6'h3F;  // 0xFC

    localparam logic [7:0]  RST_MASK     = 8'hFF;
    localparam logic [15:0] RST_PORT_EN  = 16'h2000;
    localparam logic [15:0] RST_GENERIC  = 16'h0000;
    localparam logic [31:0] RST_SELECT   = 32'h0011_2233;

    // Replace the bytes of old_v whose enable is set with those of new_v.
    function automatic logic [CFG_DW-1:0] byte_merge(
        input logic [CFG_DW-1:0]    old_v,
        input logic [CFG_DW-1:0]    new_v,
        input logic [CFG_BYTES-1:0] be
    );
        logic [CFG_DW-1:0] r;
        r = old_v;
        for (int b = 0; b < CFG_BYTES; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/lpc_cfg_regs.sv
`timescale 1ns/1ps
// Module: configuration register file.
// Holds the range bytes, decode mask, generic/port-enable words and select word.
// Assumes single-cycle write strobes; read data is a combinational mux of state.
module lpc_cfg_regs
    import lpc_fw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           addr,
    input  logic [CFG_BYTES-1:0] be,
    input  logic [CFG_DW-1:0]    wdata,
    output logic [CFG_DW-1:0]    rdata,
    output logic [7:0]           com_rng,
    output logic [7:0]           fdd_rng,
    output logic [7:0]           snd_rng,
    output logic [FW_DEVS-1:0]   fw_mask,
    output logic [15:0]          gen_dec,
    output logic [15:0]          port_en,
    output logic [31:0]          fw_select
);
    logic [5:0]        dw;
    logic [CFG_DW-1:0] merged;
    logic              unused_lo;

    assign dw        = addr[7:2];
    assign unused_lo = ^addr[1:0];

    // Read mux: implemented dwords return state, all others return zero.
    always_comb begin
        unique case (dw)
            DW_RANGES: rdata = {fw_mask, snd_rng, fdd_rng, com_rng};
            DW_DECODE: rdata = {port_en, gen_dec};
            DW_SELECT: rdata = fw_select;
            default:   rdata = '0;
        endcase
    end

    // Byte-enable merge of the write data onto the addressed dword.
    always_comb merged = byte_merge(rdata, wdata, be);

    // Register update: reset values, then merged writes per dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com_rng   <= '0;
            fdd_rng   <= '0;
            snd_rng   <= '0;
            fw_mask   <= RST_MASK;
            gen_dec   <= RST_GENERIC;
            port_en   <= RST_PORT_EN;
            fw_select <= RST_SELECT;
        end else if (wr_en) begin
            unique case (dw)
                DW_RANGES: begin
                    com_rng <= merged[7:0];
                    fdd_rng <= merged[15:8];
                    snd_rng <= merged[23:16];
                    if (be[3]) begin
                        fw_mask <= merged[31:24] | (8'h1 << FW_LOCK_BIT);
                    end
                end
                DW_DECODE: begin
                    gen_dec <= merged[15:0];
                    port_en <= merged[31:16];
                end
                DW_SELECT: fw_select <= merged;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lpc_fw_window_dec.sv
`timescale 1ns/1ps
// Module: combinational firmware window decoder.
// Each mask bit opens a primary window in the top region and a mirror window
// directly below it; the top device also owns the legacy shadow region.
// Assumes at most one window matches any address.
module lpc_fw_window_dec #(
    parameter int          ADDR_W   = 32,
    parameter int          NUM_DEV  = 8,
    parameter int          WIN_LOG2 = 19,
    parameter int          LEG_LOG2 = 17,
    parameter logic [31:0] LEG_BASE = 32'h000E_0000
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_DEV-1:0]         mask,
    output logic                       hit,
    output logic [$clog2(NUM_DEV)-1:0] sel
);
    localparam int SEL_W = $clog2(NUM_DEV);
    localparam int PFX_W = ADDR_W - (WIN_LOG2 + SEL_W + 1);

    logic               in_region;
    logic [SEL_W-1:0]   idx;
    logic               legacy_match;
    logic [NUM_DEV-1:0] dev_hit;
    logic               unused_lo;

    assign in_region    = &addr[ADDR_W-1 -: PFX_W];
    assign idx          = addr[WIN_LOG2 +: SEL_W];
    assign legacy_match = (addr[ADDR_W-1:LEG_LOG2] == LEG_BASE[ADDR_W-1:LEG_LOG2]);
    assign unused_lo    = ^{addr[WIN_LOG2+SEL_W], addr[LEG_LOG2-1:0]};

    // Per-device hit lines; the top device also takes the legacy region.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        if (d == NUM_DEV - 1) begin : g_top
            assign dev_hit[d] = mask[d] & ((in_region & (idx == SEL_W'(d))) | legacy_match);
        end else begin : g_plain
            assign dev_hit[d] = mask[d] & in_region & (idx == SEL_W'(d));
        end
    end

    // Encode the (one-hot or empty) hit vector into a device index.
    always_comb begin
        sel = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (dev_hit[d]) sel = sel | SEL_W'(d);
        end
    end

    assign hit = |dev_hit;
endmodule

// File: rtl/lpc_fw_decode_top.sv
`timescale 1ns/1ps
// Module: top of the firmware decode unit; joins the register file and the
// window decoder and brings out the super I/O port enable.
// Assumes configuration accesses are dword aligned.
module lpc_fw_decode_top
    import lpc_fw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [7:0]  cfg_addr,
    input  logic [3:0]  cfg_byte_en,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] mem_addr,
    output logic        fw_hit,
    output logic [2:0]  fw_dev_sel,
    output logic        sio_port_en
);
    logic [7:0]         com_rng, fdd_rng, snd_rng;
    logic [FW_DEVS-1:0] fw_en;
    logic [15:0]        gen_dec, lpc_en;
    logic [31:0]        fw_select;
    logic               unused_regs;

    assign unused_regs = ^{com_rng, fdd_rng, snd_rng, gen_dec, fw_select};

    lpc_cfg_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .be        (cfg_byte_en),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .com_rng   (com_rng),
        .fdd_rng   (fdd_rng),
        .snd_rng   (snd_rng),
        .fw_mask   (fw_en),
        .gen_dec   (gen_dec),
        .port_en   (lpc_en),
        .fw_select (fw_select)
    );

    lpc_fw_window_dec #(
        .ADDR_W  (32),
        .NUM_DEV (FW_DEVS)
    ) dec_i (
        .addr (mem_addr),
        .mask (fw_en),
        .hit  (fw_hit),
        .sel  (fw_dev_sel)
    );

    assign sio_port_en = lpc_en[PORT_EN_BIT];
endmodule

// File: rtl/lpc_fw_decode_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for lpc_fw_decode_top, attached with bind.
module lpc_fw_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [7:0]  cfg_addr,
    input logic [3:0]  cfg_byte_en,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [31:0] mem_addr,
    input logic        fw_hit,
    input logic [2:0]  fw_dev_sel,
    input logic        sio_port_en,
    input logic [7:0]  fw_en,
    input logic [15:0] lpc_en
);
    // R3: a write to the mask byte leaves bit 7 set
    a_r3_mask_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr[7:2] == 6'h38 && cfg_byte_en[3]) |=> fw_en[7]);

    // R8: the port-enable pin follows the written bit 29 of dword 0xE4
    a_r8_port_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr[7:2] == 6'h39 && cfg_byte_en[3]) |=> (sio_port_en == $past(cfg_wdata[29])));

    // R9: writes to dword 0xFC change no register
    a_r9_undoc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr[7:2] == 6'h3F) |=> ($stable(fw_en) && $stable(lpc_en)));

    // R10: unimplemented dwords read zero
    a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_addr[7:2] inside {6'h38, 6'h39, 6'h3A}) |-> (cfg_rdata == 32'h0));

    // R7: no hit means select zero
    a_r7_miss_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_hit |-> (fw_dev_sel == 3'd0));

    // R4/R5: a hit in the top 8 MB selects the index bits
    a_r5_window_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_hit && &mem_addr[31:23]) |-> (fw_dev_sel == mem_addr[21:19]));

    // R6: legacy region goes to device 7 when its mask bit is set
    a_r6_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[31:17] == 15'h0007 && fw_en[7]) |-> (fw_hit && fw_dev_sel == 3'd7));
endmodule

bind lpc_fw_decode_top lpc_fw_decode_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_byte_en (cfg_byte_en),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .mem_addr    (mem_addr),
    .fw_hit      (fw_hit),
    .fw_dev_sel  (fw_dev_sel),
    .sio_port_en (sio_port_en),
    .fw_en       (fw_en),
    .lpc_en      (lpc_en)
);

// File: tb/lpc_fw_decode_top_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module lpc_fw_decode_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_byte_en = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic        fw_hit;
    logic [2:0]  fw_dev_sel;
    logic        sio_port_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    lpc_fw_decode_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_byte_en(cfg_byte_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .fw_hit(fw_hit), .fw_dev_sel(fw_dev_sel),
        .sio_port_en(sio_port_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_byte_en = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_byte_en = 4'h0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic dec_check(input string req, input logic [31:0] a, input logic eh, input logic [2:0] es);
        @(negedge clk);
        mem_addr = a;
        #1;
        chk(req, {31'h0, fw_hit}, {31'h0, eh});
        chk(req, {29'h0, fw_dev_sel}, {29'h0, es});
    endtask

    task automatic test_reset();
        cfg_check("R1 ranges/mask", 8'hE0, 32'hFF00_0000);
        cfg_check("R1 decode word", 8'hE4, 32'h2000_0000);
        cfg_check("R1 select word", 8'hE8, 32'h0011_2233);
        chk("R1 R8 port pin", {31'h0, sio_port_en}, 32'h1);
    endtask

    task automatic test_byte_merge();
        cfg_write(8'hE8, 4'b0101, 32'hAABB_CCDD);
        cfg_check("R2 partial merge", 8'hE8, 32'h00BB_22DD);
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_addr = 8'hE8; cfg_byte_en = 4'hF; cfg_wdata = 32'h1234_5678;
        @(negedge clk);
        cfg_byte_en = 4'h0;
        cfg_check("R2 no write without strobe", 8'hE8, 32'h00BB_22DD);
        cfg_write(8'hE8, 4'b1111, 32'hCAFE_F00D);
        cfg_check("R11 write after edge", 8'hE8, 32'hCAFE_F00D);
    endtask

    task automatic test_mask_lock();
        cfg_write(8'hE0, 4'b1111, 32'h0544_3322);
        cfg_check("R3 lock bit forced", 8'hE0, 32'h8544_3322);
        cfg_write(8'hE0, 4'b0111, 32'h0000_0000);
        cfg_check("R3 R2 mask untouched", 8'hE0, 32'h8500_0000);
    endtask

    task automatic test_windows_partial();
        // mask 0x85: devices 0, 2, 7 enabled
        dec_check("R4 dev0 top", 32'hFFC0_0000, 1'b1, 3'd0);
        dec_check("R4 dev2 top", 32'hFFD0_0010, 1'b1, 3'd2);
        dec_check("R7 dev1 disabled", 32'hFFC8_0000, 1'b0, 3'd0);
        dec_check("R4 dev7 top", 32'hFFFF_FFFF, 1'b1, 3'd7);
        dec_check("R5 dev2 mirror", 32'hFF90_0004, 1'b1, 3'd2);
        dec_check("R7 dev1 mirror off", 32'hFF88_0000, 1'b0, 3'd0);
        dec_check("R6 legacy low", 32'h000E_0000, 1'b1, 3'd7);
        dec_check("R6 legacy high", 32'h000F_FFFF, 1'b1, 3'd7);
        dec_check("R7 below legacy", 32'h000D_FFFF, 1'b0, 3'd0);
        dec_check("R7 above legacy", 32'h0010_0000, 1'b0, 3'd0);
        dec_check("R7 below mirror", 32'hFF7F_FFFF, 1'b0, 3'd0);
    endtask

    task automatic test_mask_clear();
        cfg_write(8'hE0, 4'b1000, 32'h0000_0000);
        cfg_check("R3 clear keeps bit7", 8'hE0, 32'h8000_0000);
        dec_check("R7 dev0 cleared", 32'hFFC0_0000, 1'b0, 3'd0);
        dec_check("R6 legacy still on", 32'h000F_0000, 1'b1, 3'd7);
    endtask

    task automatic test_windows_all();
        cfg_write(8'hE0, 4'b1000, 32'hFF00_0000);
        for (int n = 0; n < 8; n++) begin
            dec_check("R4 sweep top", 32'hFFC0_0000 + n * 32'h8_0000 + 32'h7_FFFF, 1'b1, 3'(n));
            dec_check("R5 sweep mirror", 32'hFF80_0000 + n * 32'h8_0000, 1'b1, 3'(n));
        end
    endtask

    task automatic test_port_enable();
        cfg_write(8'hE4, 4'b1000, 32'h0000_0000);
        chk("R8 pin low", {31'h0, sio_port_en}, 32'h0);
        cfg_write(8'hE4, 4'b0011, 32'hFFFF_ABCD);
        cfg_check("R8 generic word", 8'hE4, 32'h0000_ABCD);
        chk("R8 pin stays low", {31'h0, sio_port_en}, 32'h0);
        cfg_write(8'hE4, 4'b1100, 32'h2000_0000);
        chk("R8 pin high", {31'h0, sio_port_en}, 32'h1);
        cfg_check("R8 decode dword", 8'hE4, 32'h2000_ABCD);
    endtask

    task automatic test_undoc();
        cfg_write(8'hFC, 4'b1111, 32'hFFFF_FFFF);
        cfg_check("R9 reads zero", 8'hFC, 32'h0);
        cfg_check("R9 mask unchanged", 8'hE0, 32'hFF00_0000);
        cfg_check("R9 decode unchanged", 8'hE4, 32'h2000_ABCD);
        cfg_check("R9 select unchanged", 8'hE8, 32'hCAFE_F00D);
        chk("R9 pin unchanged", {31'h0, sio_port_en}, 32'h1);
    endtask

    task automatic test_unimpl();
        cfg_check("R10 offset 00", 8'h00, 32'h0);
        cfg_check("R10 offset DC", 8'hDC, 32'h0);
        cfg_check("R10 offset EC", 8'hEC, 32'h0);
        cfg_check("R10 offset F0", 8'hF0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_byte_merge();
        test_mask_lock();
        test_windows_partial();
        test_mask_clear();
        test_windows_all();
        test_port_enable();
        test_undoc();
        test_unimpl();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule